// File: doc/BRIEF.md
# Printer Port Register Interface

This block is the byte-wide register front end of a standard printer port, seen from a host bus. The host selects one of eight byte registers through a register offset, writes with `wr_en` and reads with `rd_en`. A level interrupt output reports a pending acknowledge event. Inside the block sit a write data latch, a read data latch, a status byte and a control byte. The printer side of the strobe, busy and acknowledge handshake is modelled inside the block, so software sees a printer answer without any external pins. Each byte that the strobe hands over appears on `byte_out` with a one-clock `byte_valid` pulse.

The bus is memory mapped. The register offset is the low three bits of the bus address after a right shift by `IT_SHIFT`, so registers can sit at byte, halfword or word spacing. Accesses of any width reach the same byte registers. Reads are zero-extended to the bus width, and only the low byte of write data is used.

The handshake is a four-state machine on the top two status bits, written {not-busy, ack}. The states are: HS_IDLE (11, ready with ack high), HS_TAKEN (01, busy after a strobe), HS_ACKLOW (00, busy with ack pulsed low) and HS_ODD (10, ready with ack low, reached only from outside the normal flow). The transitions are:
- FORCE_INIT: any state goes to HS_IDLE when a control write clears the initialize bit.
- STROBE_CLEAR: a control write with select-in and strobe set clears not-busy. HS_IDLE goes to HS_TAKEN and HS_ODD goes to HS_ACKLOW.
- READ_STEP: a status read while busy and while the stored strobe bit is clear moves HS_TAKEN to HS_ACKLOW and HS_ACKLOW to HS_IDLE.

Top module: `prt_port_regs`

## Requirements
- R1: After reset, offset 0 reads 0xFF, offset 1 (status) reads 0xD9, offset 2 (control) reads 0xCC, and `irq` is low.
- R2: A write to offset 2 stores the written byte with bits 7 and 6 forced to 1. Reading offset 2 returns the stored value.
- R3: A control write whose bit 2 (initialize, active low) is 0 sets the status byte to 0xD8.
- R4: A control write with bits 2, 3 and 0 all 1 clears status bit 7. If bit 0 of the previously stored control byte was 0, the write data latch appears on `byte_out` with `byte_valid` high in the clock after the write. Otherwise `byte_valid` stays low.
- R5: A control write with bits 2 and 3 set and bit 0 clear raises `irq` in the next clock if bit 4 (interrupt enable) of the previously stored control byte was 1.
- R6: A read of offset 1 returns the current status byte, and `irq` is low from the next clock on.
- R7: A status read while status bit 7 is 0 and stored control bit 0 is 0 updates the status. If bit 6 was 1 it is cleared; otherwise bits 7 and 6 are both set.
- R8: A read of offset 0 returns the read latch (0xFF) when control bit 5 is 1, and the write data latch when it is 0. A write to offset 0 loads the write data latch.
- R9: Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change no register.
- R10: The offset is bits [2:0] of `bus_addr >> IT_SHIFT`. Other address bits and write data bits above bit 7 have no effect, and read data above bit 7 is zero.
- R11: `byte_valid` is never high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus byte address |
| wr_en | input | 1 | Write strobe for the access cycle |
| rd_en | input | 1 | Read strobe; ignored when wr_en is high |
| wr_data | input | BUS_W | Write data; low byte used |
| rd_data | output | BUS_W | Read data of the addressed register, zero-extended |
| irq | output | 1 | Level interrupt, equal to the pending flag |
| byte_out | output | 8 | Byte handed over by the strobe |
| byte_valid | output | 1 | One-clock marker for byte_out |

## Verification
The bench writes all 256 control values, each after a different prior control byte. Every combination of initialize, select-in, strobe and interrupt enable is therefore reached with both old strobe levels. A design that tested the new strobe bit instead of the old one for emission would emit a byte on repeated strobes or never emit one. A design that took interrupt enable from the new value would raise the interrupt on the wrong writes. Three status reads follow each write and walk the acknowledge sequence, so a wrong order of the ack and busy updates shows up as a wrong status byte. Salted address and data bits check that the shifted decode, the ignored offsets and the zero-extension hold. A design that decoded unshifted bits would reach the wrong registers.

// File: rtl/prt_pkg.sv
package prt_pkg;
    localparam int BYTE_W = 8;

    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CTRL = 3'd2;

    localparam int CT_DIR   = 5;
    localparam int CT_IEN   = 4;
    localparam int CT_SEL   = 3;
    localparam int CT_NINIT = 2;
    localparam int CT_STB   = 0;

    localparam logic [7:0] CTRL_FORCE    = 8'hC0;
    localparam logic [7:0] CTRL_RST      = 8'hCC;
    localparam logic [7:0] LATCH_RST     = 8'hFF;
    localparam logic [7:0] UNMAPPED_READ = 8'hFF;
    localparam logic [5:0] ST_LOW_RST    = 6'h19;
    localparam logic [5:0] ST_LOW_INIT   = 6'h18;

    // {not-busy, ack}
    typedef enum logic [1:0] {
        HS_ACKLOW = 2'b00,
        HS_TAKEN  = 2'b01,
        HS_ODD    = 2'b10,
        HS_IDLE   = 2'b11
    } hs_state_t;
endpackage

// File: rtl/prt_decode.sv
module prt_decode #(
    parameter int ADDR_W   = 8,
    parameter int IT_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [2:0]        off,
    output logic              wr_data_sel,
    output logic              wr_ctrl_sel,
    output logic              rd_stat_sel
);
    import prt_pkg::*;

    logic [ADDR_W-1:0] shifted;
    logic              unused_hi;

    assign shifted   = bus_addr >> IT_SHIFT;
    assign off       = shifted[2:0];
    assign unused_hi = ^shifted[ADDR_W-1:3];

    always_comb begin
        wr_data_sel = 1'b0;
        wr_ctrl_sel = 1'b0;
        rd_stat_sel = 1'b0;
        if (wr_en) begin
            wr_data_sel = (off == OFF_DATA);
            wr_ctrl_sel = (off == OFF_CTRL);
        end else if (rd_en) begin
            rd_stat_sel = (off == OFF_STAT);
        end
    end
endmodule

// File: rtl/prt_status.sv
module prt_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_init,
    input  logic       clear_busy,
    input  logic       stat_read,
    input  logic       ctrl_strobe,
    output logic [7:0] status_o
);
    import prt_pkg::*;

    hs_state_t   hs_q, hs_d;
    logic [5:0]  low_q, low_d;
    logic        read_step;

    assign read_step = stat_read && !ctrl_strobe;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q  <= HS_IDLE;
            low_q <= ST_LOW_RST;
        end else begin
            hs_q  <= hs_d;
            low_q <= low_d;
        end
    end

    // next state
    always_comb begin
        hs_d  = hs_q;
        low_d = low_q;
        if (force_init) begin
            hs_d  = HS_IDLE;
            low_d = ST_LOW_INIT;
        end else begin
            unique case (hs_q)
                HS_IDLE: begin
                    if (clear_busy) hs_d = HS_TAKEN;
                end
                HS_ODD: begin
                    if (clear_busy) hs_d = HS_ACKLOW;
                end
                HS_TAKEN: begin
                    if (!clear_busy && read_step) hs_d = HS_ACKLOW;
                end
                HS_ACKLOW: begin
                    if (!clear_busy && read_step) hs_d = HS_IDLE;
                end
                default: hs_d = HS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        status_o = {hs_q, low_q};
    end
endmodule

// File: rtl/prt_ctrl.sv
module prt_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_data_sel,
    input  logic       wr_ctrl_sel,
    input  logic       rd_stat_sel,
    input  logic [7:0] wbyte,
    output logic [7:0] ctrl_o,
    output logic [7:0] dataw_o,
    output logic       irq_o,
    output logic [7:0] byte_out,
    output logic       byte_valid,
    output logic       force_init,
    output logic       clear_busy
);
    import prt_pkg::*;

    logic [7:0] ctrl_q, dataw_q, out_q, new_ctrl;
    logic       irq_q, valid_q, emit, irq_set;

    assign new_ctrl   = wbyte | CTRL_FORCE;
    assign force_init = wr_ctrl_sel && !new_ctrl[CT_NINIT];
    assign clear_busy = wr_ctrl_sel && new_ctrl[CT_NINIT] && new_ctrl[CT_SEL]
                        && new_ctrl[CT_STB];
    assign emit       = clear_busy && !ctrl_q[CT_STB];
    assign irq_set    = wr_ctrl_sel && new_ctrl[CT_NINIT] && new_ctrl[CT_SEL]
                        && !new_ctrl[CT_STB] && ctrl_q[CT_IEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            dataw_q <= LATCH_RST;
            irq_q   <= 1'b0;
            out_q   <= LATCH_RST;
            valid_q <= 1'b0;
        end else begin
            if (wr_ctrl_sel) ctrl_q <= new_ctrl;
            if (wr_data_sel) dataw_q <= wbyte;
            if (irq_set) irq_q <= 1'b1;
            else if (rd_stat_sel) irq_q <= 1'b0;
            valid_q <= emit;
            if (emit) out_q <= dataw_q;
        end
    end

    always_comb begin
        ctrl_o     = ctrl_q;
        dataw_o    = dataw_q;
        irq_o      = irq_q;
        byte_out   = out_q;
        byte_valid = valid_q;
    end
endmodule

// File: rtl/prt_port_regs.sv
module prt_port_regs #(
    parameter int ADDR_W   = 8,
    parameter int IT_SHIFT = 2,
    parameter int BUS_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq,
    output logic [7:0]        byte_out,
    output logic              byte_valid
);
    import prt_pkg::*;

    localparam int PAD_W = BUS_W - BYTE_W;

    logic [2:0] off;
    logic       wr_data_sel, wr_ctrl_sel, rd_stat_sel;
    logic       force_init, clear_busy;
    logic [7:0] ctrl_w, dataw_w, status_w, rd_byte;
    logic [7:0] rd_latch_q;
    logic       unused_wd;

    assign unused_wd = ^wr_data[BUS_W-1:BYTE_W];

    prt_decode #(.ADDR_W(ADDR_W), .IT_SHIFT(IT_SHIFT)) u_dec (
        .bus_addr    (bus_addr),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .off         (off),
        .wr_data_sel (wr_data_sel),
        .wr_ctrl_sel (wr_ctrl_sel),
        .rd_stat_sel (rd_stat_sel)
    );

    prt_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data_sel (wr_data_sel),
        .wr_ctrl_sel (wr_ctrl_sel),
        .rd_stat_sel (rd_stat_sel),
        .wbyte       (wr_data[BYTE_W-1:0]),
        .ctrl_o      (ctrl_w),
        .dataw_o     (dataw_w),
        .irq_o       (irq),
        .byte_out    (byte_out),
        .byte_valid  (byte_valid),
        .force_init  (force_init),
        .clear_busy  (clear_busy)
    );

    prt_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_init  (force_init),
        .clear_busy  (clear_busy),
        .stat_read   (rd_stat_sel),
        .ctrl_strobe (ctrl_w[CT_STB]),
        .status_o    (status_w)
    );

    // read latch: no external source is attached, it holds its reset value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_latch_q <= LATCH_RST;
        else        rd_latch_q <= rd_latch_q;
    end

    always_comb begin
        unique case (off)
            OFF_DATA: rd_byte = ctrl_w[CT_DIR] ? rd_latch_q : dataw_w;
            OFF_STAT: rd_byte = status_w;
            OFF_CTRL: rd_byte = ctrl_w;
            default:  rd_byte = UNMAPPED_READ;
        endcase
        rd_data = {{PAD_W{1'b0}}, rd_byte};
    end
endmodule

// File: rtl/prt_port_regs_chk.sv
module prt_port_regs_chk #(
    parameter int ADDR_W   = 8,
    parameter int IT_SHIFT = 2,
    parameter int BUS_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BUS_W-1:0]  wr_data,
    input logic              irq,
    input logic [7:0]        byte_out,
    input logic              byte_valid,
    input logic [7:0]        ctrl_q,
    input logic [7:0]        status_q,
    input logic [7:0]        dataw_q
);
    logic [ADDR_W-1:0] sh;
    logic [2:0]        off;
    logic [7:0]        wb;
    logic              cw, unused_chk;

    assign sh  = bus_addr >> IT_SHIFT;
    assign off = sh[2:0];
    assign wb  = wr_data[7:0];
    assign cw  = wr_en && (off == 3'd2);
    assign unused_chk = ^{sh[ADDR_W-1:3], wr_data[BUS_W-1:8]};

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    p_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && wb[3] && wb[2] && wb[0] && !ctrl_q[0])
        |=> (byte_valid && byte_out == $past(dataw_q) && !status_q[7]));

    p_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && !wb[2]) |=> (status_q == 8'hD8));

    p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && wb[3] && wb[2] && !wb[0] && ctrl_q[4]) |=> irq);

    p_irq_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && off == 3'd1) |=> !irq);

    p_ctrl_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (ctrl_q == ($past(wb) | 8'hC0)));

    p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off != 3'd0 && off != 3'd2)
        |=> ($stable(ctrl_q) && $stable(dataw_q) && $stable(status_q) && $stable(irq)));
endmodule

bind prt_port_regs prt_port_regs_chk #(
    .ADDR_W(ADDR_W), .IT_SHIFT(IT_SHIFT), .BUS_W(BUS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wr_data    (wr_data),
    .irq        (irq),
    .byte_out   (byte_out),
    .byte_valid (byte_valid),
    .ctrl_q     (ctrl_w),
    .status_q   (status_w),
    .dataw_q    (dataw_w)
);

// File: tb/sim_prt_port_regs.sv
module sim_prt_port_regs;
    localparam int ADDR_W   = 8;
    localparam int IT_SHIFT = 2;
    localparam int BUS_W    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [BUS_W-1:0]  wr_data = '0;
    logic [BUS_W-1:0]  rd_data;
    logic              irq;
    logic [7:0]        byte_out;
    logic              byte_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the register state, built from the requirements
    logic [7:0] m_dw = 8'hFF;
    logic [7:0] m_st = 8'hD9;
    logic [7:0] m_ct = 8'hCC;
    logic       m_irq = 1'b0;

    always #10 clk = ~clk;

    prt_port_regs #(.ADDR_W(ADDR_W), .IT_SHIFT(IT_SHIFT), .BUS_W(BUS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
        .byte_out(byte_out), .byte_valid(byte_valid)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] addr_of(input logic [2:0] off, input int salt);
        logic [7:0] s;
        s = 8'(salt);
        return {s[2:0], off, s[4:3]};
    endfunction

    task automatic wr(input logic [2:0] off, input logic [7:0] val, input int salt);
        logic emit;
        logic [7:0] v;
        emit = 1'b0;
        v = val | 8'hC0;
        if (off == 3'd0) m_dw = val;
        if (off == 3'd2) begin
            if (!v[2]) m_st = 8'hD8;
            else if (v[3]) begin
                if (v[0]) begin
                    m_st[7] = 1'b0;
                    emit = !m_ct[0];
                end else if (m_ct[4]) m_irq = 1'b1;
            end
            m_ct = v;
        end
        @(negedge clk);
        bus_addr = addr_of(off, salt);
        wr_data  = {8'(salt * 3), 8'(salt >> 2), 8'hA5, val};
        wr_en    = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        @(negedge clk);
        if (off == 3'd2) begin
            chk("R4", {31'd0, byte_valid}, {31'd0, emit});
            if (emit) chk("R4", {24'd0, byte_out}, {24'd0, m_dw});
            @(negedge clk);
            chk("R11", {31'd0, byte_valid}, 32'd0);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] off, input int salt);
        logic [7:0] exp;
        logic [31:0] got;
        case (off)
            3'd0:    exp = m_ct[5] ? 8'hFF : m_dw;
            3'd1:    exp = m_st;
            3'd2:    exp = m_ct;
            default: exp = 8'hFF;
        endcase
        @(negedge clk);
        bus_addr = addr_of(off, salt);
        rd_en    = 1'b1;
        #5 got = rd_data;
        @(posedge clk);
        #1 rd_en = 1'b0;
        chk(req, got, {24'd0, exp});
        if (off == 3'd1) begin
            m_irq = 1'b0;
            if (!m_st[7] && !m_ct[0]) begin
                if (m_st[6]) m_st[6] = 1'b0;
                else m_st = m_st | 8'hC0;
            end
        end
    endtask

    task automatic irq_chk(input string req);
        @(negedge clk);
        chk(req, {31'd0, irq}, {31'd0, m_irq});
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] prior;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        irq_chk("R1");
        rd_chk("R1", 3'd0, 0);
        rd_chk("R1", 3'd1, 5);
        rd_chk("R1", 3'd2, 9);
        chk("R1", {31'd0, byte_valid}, 32'd0);

        // R9 unmapped reads and ignored writes, R10 salted addresses
        for (int o = 3; o < 8; o++) rd_chk("R9", 3'(o), o * 7);
        wr(3'd1, 8'h00, 3);
        for (int o = 3; o < 8; o++) wr(3'(o), 8'h00, o * 5);
        rd_chk("R9", 3'd0, 1);
        rd_chk("R9", 3'd2, 2);
        rd_chk("R9", 3'd1, 4);
        irq_chk("R9");

        // sweep every control value after a varied prior value
        for (int i = 0; i < 256; i++) begin
            prior = {i[3:0], i[7:4]} ^ 8'h1D;
            wr(3'd0, 8'(i * 37 + 11), i);
            wr(3'd2, prior, i + 1);
            wr(3'd2, 8'(i), i + 2);
            irq_chk("R5");
            rd_chk("R2", 3'd2, i + 3);
            rd_chk(i[2] ? "R7" : "R3", 3'd1, i + 4);
            irq_chk("R6");
            rd_chk("R7", 3'd1, i + 5);
            rd_chk("R7", 3'd1, i + 6);
            rd_chk("R8", 3'd0, i + 7);
            rd_chk("R10", 3'(i % 8), i * 11);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule